// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-side engine of a 64 KiB serial memory that sits on a two-wire clock/data bus. It oversamples SCL and the SDA line with the system clock through a synchroniser, and recognises start and stop conditions from SDA transitions while SCL is high. Bytes are shifted MSB first. The block checks the device-select byte against a fixed prefix and three strap pins, and it acknowledges by pulling SDA low through an open-drain enable.

After a write-mode select, the next two bytes load a 16-bit word pointer, high byte first. Every later byte goes to the memory side as a write strobe with its address and data, and a stop condition closes the write with a single commit pulse. A read-mode select streams bytes from the pointer onward for as long as the master acknowledges. A random read is a write-mode select plus the two address bytes, then a repeated start and a read-mode select. While the memory side reports a write cycle in progress, the device select is left unacknowledged, so a host can poll for completion.

Top module: `eep_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) aborts any transfer in any state, drops any uncommitted write, releases SDA and restarts device-select reception. A rising SDA while SCL is high (stop) returns the block to idle with SDA released.
- R2: The select byte is accepted only when its upper four bits equal 1010 and bits 3..1 equal `strap[2:0]` (bit 3 = strap[2]). Bit 0 chooses read (1) or write (0).
- R3: For every accepted byte, `sda_oe` rises after the SCL fall that ends the eighth bit and drops after the SCL fall that ends the ninth clock, so the master sees SDA low during the ninth SCL high phase.
- R4: After a write-mode select, the first byte received is the pointer's high byte and the second is its low byte. Both are acknowledged.
- R5: Each later byte is acknowledged and produces a one-cycle `wr_req` with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pointer's low 7 bits then increment and wrap within the 128-byte page, and the high bits do not change.
- R6: A stop after at least one data byte of a write produces exactly one `wr_commit` pulse. A stop after a transfer with no data byte produces none.
- R7: While `mem_busy` is high at the end of a select byte, the select is not acknowledged, and all further traffic is ignored until the next start.
- R8: An accepted read-mode select, and every master acknowledge during a read, produces a one-cycle `rd_req` with `rd_addr` equal to the pointer, and the pointer then advances by one, wrapping from 0xFFFF to 0x0000. `rd_data` must be valid one clock after `rd_req` and held until the next `rd_req`. The byte is driven MSB first, and each bit is changed only while SCL is low.
- R9: A master acknowledge (SDA low on the ninth clock of a read byte) continues with the next byte. A no-acknowledge releases SDA, and the block then ignores the bus until a start or stop.
- R10: A read-mode select returns data from the pointer as it was left by the previous access (last byte accessed plus one). After a write-mode select with two address bytes and a repeated start, that address is read.
- R11: A select byte that does not match is not acknowledged, and the block then neither acknowledges nor strobes anything until the next start.
- R12: While `rst` is high, the block stays idle, keeps SDA released and does not react to the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 3 | Device address strap pins |
| mem_busy | input | 1 | Memory write cycle in progress |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain pull-low enable for SDA |
| wr_req | output | 1 | Write strobe for one byte |
| wr_addr | output | 16 | Write byte address |
| wr_data | output | 8 | Write byte value |
| wr_commit | output | 1 | Write sequence closed by stop |
| rd_req | output | 1 | Read request strobe |
| rd_addr | output | 16 | Read byte address |
| rd_data | input | 8 | Read data, valid one clock after rd_req |

## Verification
A start condition can arrive in the same system cycle that the sequencer would otherwise handle an SCL edge, shift a bit or make an acknowledge decision. The start has to win, so no partly received byte updates the pointer or produces a write strobe. The bench provokes this by issuing a repeated start after only four bits of an address byte. It then judges the outcome at the ports: the read-mode select that follows must be acknowledged, no `wr_req` may appear, and the byte returned must come from the pointer left by the previous read rather than from any partial address.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
    localparam int         STRAP_W    = 3;
    localparam int         BYTE_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } seq_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic sel_match(logic [BYTE_W-1:0] b, logic [STRAP_W-1:0] s);
        return (b[7:4] == DEV_PREFIX) && (b[3:1] == s);
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    if (STAGES > 1) begin : g_multi
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_q <= '1;
                sda_q <= '1;
            end else begin
                scl_q <= {scl_q[STAGES-2:0], scl_i};
                sda_q <= {sda_q[STAGES-2:0], sda_i};
            end
        end
    end else begin : g_single
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_q <= '1;
                sda_q <= '1;
            end else begin
                scl_q <= scl_i;
                sda_q <= sda_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_q[STAGES-1];
        ev.sda   = sda_q[STAGES-1];
        ev.rise  = ev.scl & ~scl_p;
        ev.fall  = ~ev.scl & scl_p;
        ev.start = ev.scl & scl_p & sda_p & ~ev.sda;
        ev.stop  = ev.scl & scl_p & ~sda_p & ev.sda;
    end

endmodule

// File: rtl/eep_seq.sv
module eep_seq
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_ev_t             ev,
    input  logic [STRAP_W-1:0]  strap,
    input  logic                mem_busy,
    output logic                sda_oe,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                wr_commit,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0]   rd_data
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_BITS) - 1);
    localparam logic [3:0]        ACK_SLOT  = 4'd8;
    localparam logic [3:0]        END_SLOT  = 4'd9;

    seq_st_e            st, pend;
    logic [3:0]         bit_cnt;
    logic [BYTE_W-1:0]  sh;
    logic [BYTE_W-1:0]  tx;
    logic [BYTE_W-1:0]  addr_hi;
    logic [ADDR_W-1:0]  ptr;
    logic [ADDR_W-1:0]  ptr_page_nxt;
    logic [2:0]         tx_idx;
    logic               dirty;
    logic               active;

    assign ptr_page_nxt = (ptr & ~PAGE_MASK) | ((ptr + ADDR_W'(1)) & PAGE_MASK);
    assign tx_idx       = 3'(4'd7 - bit_cnt);
    assign active       = (st != ST_IDLE) && (st != ST_SKIP);

    always_ff @(posedge clk) begin
        wr_req    <= 1'b0;
        rd_req    <= 1'b0;
        wr_commit <= 1'b0;
        if (rst) begin
            st      <= ST_IDLE;
            pend    <= ST_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            tx      <= '0;
            addr_hi <= '0;
            ptr     <= '0;
            dirty   <= 1'b0;
            sda_oe  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rd_addr <= '0;
        end else if (ev.start) begin
            st      <= ST_DEV;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            dirty   <= 1'b0;
        end else if (ev.stop) begin
            st        <= ST_IDLE;
            sda_oe    <= 1'b0;
            wr_commit <= dirty;
            dirty     <= 1'b0;
        end else if (active) begin
            if (ev.rise) begin
                if (bit_cnt < ACK_SLOT) sh <= {sh[BYTE_W-2:0], ev.sda};
                bit_cnt <= bit_cnt + 4'd1;
                if (st == ST_RDAT && bit_cnt == ACK_SLOT) begin
                    if (!ev.sda) begin
                        pend    <= ST_RDAT;
                        rd_req  <= 1'b1;
                        rd_addr <= ptr;
                        ptr     <= ptr + ADDR_W'(1);
                    end else begin
                        pend <= ST_SKIP;
                    end
                end
            end else if (ev.fall) begin
                if (bit_cnt == ACK_SLOT && st != ST_RDAT) begin
                    unique case (st)
                        ST_DEV: begin
                            if (sel_match(sh, strap) && !mem_busy) begin
                                sda_oe <= 1'b1;
                                if (sh[0]) begin
                                    pend    <= ST_RDAT;
                                    rd_req  <= 1'b1;
                                    rd_addr <= ptr;
                                    ptr     <= ptr + ADDR_W'(1);
                                end else begin
                                    pend <= ST_AHI;
                                end
                            end else begin
                                st     <= ST_SKIP;
                                sda_oe <= 1'b0;
                            end
                        end
                        ST_AHI: begin
                            addr_hi <= sh;
                            sda_oe  <= 1'b1;
                            pend    <= ST_ALO;
                        end
                        ST_ALO: begin
                            ptr    <= ADDR_W'({addr_hi, sh});
                            sda_oe <= 1'b1;
                            pend   <= ST_WDAT;
                        end
                        default: begin
                            wr_req  <= 1'b1;
                            wr_addr <= ptr;
                            wr_data <= sh;
                            ptr     <= ptr_page_nxt;
                            dirty   <= 1'b1;
                            sda_oe  <= 1'b1;
                            pend    <= ST_WDAT;
                        end
                    endcase
                end else if (bit_cnt == END_SLOT) begin
                    st      <= pend;
                    bit_cnt <= '0;
                    if (pend == ST_RDAT) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end else if (st == ST_RDAT) begin
                    sda_oe <= (bit_cnt < ACK_SLOT) ? ~tx[tx_idx] : 1'b0;
                end
            end
        end
    end

    // R1: a start always leaves the sequencer waiting for a select byte with SDA free
    p_start_resync_r1: assert property (@(posedge clk) disable iff (rst)
        $past(ev.start) |-> (st == ST_DEV && bit_cnt == 4'd0 && !sda_oe));

    // R3: SDA drive only changes while SCL is low, apart from start/stop aborts
    p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        ((sda_oe != $past(sda_oe)) && !$past(ev.start) && !$past(ev.stop)) |-> !$past(ev.scl));

    // R6: a commit is always the consequence of a stop
    p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(ev.stop));

    // R8: the transmitted bit is held through the SCL high phase
    p_tx_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDAT && ev.scl && $past(ev.scl)) |-> $stable(sda_oe));

    // R11: idle and ignoring states never pull SDA
    p_quiet_release_r11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe);

    // R5: memory-side strobes never overlap
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_req, rd_req, wr_commit}));

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BITS   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          strap,
    input  logic                mem_busy,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [7:0]          wr_data,
    output logic                wr_commit,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [7:0]          rd_data
);

    bus_ev_t ev;

    eep_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_seq #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (strap),
        .mem_busy  (mem_busy),
        .sda_oe    (sda_oe),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/eep_i2c_slave_tb_top.sv
module eep_i2c_slave_tb_top;

    localparam int Q = 4;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};
    // {start address, byte count, spare}
    localparam logic [31:0] RD_VEC [4] = '{
        {16'h0010, 8'd3, 8'd0},
        {16'hFFFE, 8'd4, 8'd0},
        {16'h1234, 8'd1, 8'd0},
        {16'h00FF, 8'd2, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic        mem_busy = 1'b0;
    logic        sda_oe;
    logic        wr_req, wr_commit, rd_req;
    logic [15:0] wr_addr, rd_addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data = 8'h00;
    wire         sda_line = msda & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int commit_cnt = 0;
    int rd_cnt = 0;
    logic [15:0] wlog_a [16];
    logic [7:0]  wlog_d [16];
    logic [15:0] exp_ptr;
    bit done = 0;

    always #10 clk = ~clk;

    eep_i2c_slave dut_i (
        .clk(clk), .rst(rst), .strap(STRAP), .mem_busy(mem_busy),
        .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] mdl(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(posedge clk) if (rd_req) rd_data <= mdl(rd_addr);

    always @(negedge clk) begin
        if (wr_req) begin
            wlog_a[wr_cnt % 16] = wr_addr;
            wlog_d[wr_cnt % 16] = wr_data;
            wr_cnt++;
        end
        if (wr_commit) commit_cnt++;
        if (rd_req) rd_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic b_start();
        msda = 1'b1; wq(); scl = 1'b1; wq(); msda = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic b_stop();
        msda = 1'b0; wq(); scl = 1'b1; wq(); msda = 1'b1; wq();
    endtask

    task automatic b_bit(input logic b);
        msda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic b_send(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) b_bit(v[i]);
        msda = 1'b1; wq(); scl = 1'b1; wq();
        ack = ~sda_line;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic b_recv(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            msda = 1'b1; wq(); scl = 1'b1; wq();
            v[i] = sda_line;
            wq(); scl = 1'b0; wq();
        end
        b_bit(~mack);
        msda = 1'b1;
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        int w0, c0, r0;

        // R12: bus traffic during reset is ignored
        repeat (3) @(negedge clk);
        b_start();
        b_send(SEL_W, ack);
        chk(ack == 1'b0, "R12 no ack in reset", ack, 0);
        b_stop();
        chk(sda_oe == 1'b0 && wr_cnt == 0, "R12 reset state", {sda_oe, 8'(wr_cnt)}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R4 R5 R6: page write with in-page wrap
        b_start();
        b_send(SEL_W, ack); chk(ack, "R2 select ack", ack, 1);
        b_send(8'h12, ack); chk(ack, "R4 addr hi ack", ack, 1);
        b_send(8'h7E, ack); chk(ack, "R4 addr lo ack", ack, 1);
        b_send(8'h11, ack); chk(ack, "R3 data ack", ack, 1);
        b_send(8'h22, ack);
        b_send(8'h33, ack); chk(ack, "R5 data ack after wrap", ack, 1);
        b_stop();
        repeat (4) @(negedge clk);
        chk(wr_cnt == 3, "R5 write count", wr_cnt, 3);
        chk(wlog_a[0] == 16'h127E && wlog_d[0] == 8'h11, "R5 byte0", {wlog_a[0], wlog_d[0]}, {16'h127E, 8'h11});
        chk(wlog_a[1] == 16'h127F && wlog_d[1] == 8'h22, "R5 byte1", {wlog_a[1], wlog_d[1]}, {16'h127F, 8'h22});
        chk(wlog_a[2] == 16'h1200 && wlog_d[2] == 8'h33, "R5 page wrap", {wlog_a[2], wlog_d[2]}, {16'h1200, 8'h33});
        chk(commit_cnt == 1, "R6 one commit", commit_cnt, 1);
        exp_ptr = 16'h1201;

        // R10 R9: current address read, master nack releases SDA
        b_start();
        b_send(SEL_R, ack); chk(ack, "R10 read select ack", ack, 1);
        b_recv(v, 1'b0);
        chk(v == mdl(exp_ptr), "R10 current address data", v, mdl(exp_ptr));
        @(negedge clk);
        chk(sda_oe == 1'b0, "R9 release after nack", sda_oe, 0);
        b_stop();
        exp_ptr = exp_ptr + 16'd1;

        // R7: busy polling
        mem_busy = 1'b1;
        w0 = wr_cnt; c0 = commit_cnt;
        b_start();
        b_send(SEL_W, ack); chk(!ack, "R7 busy nack", ack, 0);
        b_send(8'h00, ack); chk(!ack, "R7 ignored after nack", ack, 0);
        b_stop();
        mem_busy = 1'b0;
        b_start();
        b_send(SEL_W, ack); chk(ack, "R7 ack when idle", ack, 1);
        b_stop();
        repeat (4) @(negedge clk);
        chk(wr_cnt == w0 && commit_cnt == c0, "R6 no commit without data", commit_cnt, c0);

        // R11 R2: mismatching selects
        b_start();
        b_send({4'b1010, 3'b001, 1'b0}, ack); chk(!ack, "R11 strap mismatch", ack, 0);
        b_send(8'h55, ack); chk(!ack, "R11 traffic ignored", ack, 0);
        b_stop();
        b_start();
        b_send({4'b1011, STRAP, 1'b0}, ack); chk(!ack, "R2 prefix mismatch", ack, 0);
        b_stop();
        repeat (4) @(negedge clk);
        chk(wr_cnt == w0, "R11 no write strobe", wr_cnt, w0);

        // R1: restart in the middle of an address byte
        r0 = rd_cnt;
        b_start();
        b_send(SEL_W, ack);
        b_send(8'h40, ack);
        for (int i = 0; i < 4; i++) b_bit(1'b0);
        b_start();
        b_send(SEL_R, ack); chk(ack, "R1 select after restart", ack, 1);
        b_recv(v, 1'b0);
        chk(v == mdl(exp_ptr), "R1 pointer untouched by abort", v, mdl(exp_ptr));
        b_stop();
        chk(wr_cnt == w0 && rd_cnt == r0 + 1, "R1 no stray strobes", rd_cnt, r0 + 1);

        // R8 R9 R10: random and sequential reads from the table
        foreach (RD_VEC[k]) begin
            logic [15:0] a;
            int n;
            a = RD_VEC[k][31:16];
            n = int'(RD_VEC[k][15:8]);
            b_start();
            b_send(SEL_W, ack);
            b_send(a[15:8], ack);
            b_send(a[7:0], ack);
            b_start();
            b_send(SEL_R, ack); chk(ack, "R10 random read select", ack, 1);
            for (int j = 0; j < n; j++) begin
                logic [15:0] ea;
                ea = a + 16'(j);
                b_recv(v, j != n - 1);
                chk(v == mdl(ea), "R8 sequential byte", v, mdl(ea));
            end
            b_stop();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule